// File: doc/BRIEF.md
# Aligned Load/Store Lane Unit

This unit sits between a 64-bit integer datapath and a byte-addressed memory port that is 64 bits wide. A request carries a byte address, an access size, a signedness flag, a floating-point flag, a write flag and store data. The unit checks that the address is naturally aligned for the access size. A misaligned request never reaches memory. Instead it produces a one-cycle trap pulse and reports the faulting address.

For an aligned request the unit issues one memory beat with the 8-byte-aligned address. For stores, it also drives per-lane byte enables and the store data moved into the addressed lanes. When the load data returns, the unit picks the addressed lanes out of the 64-bit word. It then zero-extends or sign-extends them to 64 bits and presents the result one cycle later. A floating-point mode treats the access as 32 bits. In that mode the loaded value fills the low half of the result and the upper half is zero.

Only one load is outstanding at a time. The request side stalls until that load's data has returned. Stores and trapped requests never stall the request side.

Top module: `lsu_align_ext`

## Requirements
- R1: An access of n bytes (n = 1, 2, 4, 8 for size codes 0, 1, 2, 3) is misaligned when address modulo n is not zero. A misaligned accepted request drives trap_pulse high for exactly the cycle after acceptance, with trap_addr equal to the full request address. In that cycle mem_valid is 0 and mem_be is 0.
- R2: An aligned accepted request drives mem_valid high in the cycle after acceptance. In that cycle mem_addr equals the request address with bits 2:0 cleared, mem_we equals the request write flag, and trap_pulse is 0.
- R3: With off = address bits 2:0, mem_be bit k is 1 exactly for off <= k < off+n. Lane k carries memory bits 8k+7:8k, so the ordering is little-endian.
- R4: For a store, mem_wdata carries the low n bytes of req_wdata placed starting at lane off. Every other lane is zero.
- R5: For a load with req_signed = 0, the result holds lanes off..off+n-1 of mem_rdata in its low n bytes, and all higher bytes are zero.
- R6: For a load with req_signed = 1 and n < 8, every result bit above the loaded bytes equals the most significant bit of the loaded value.
- R7: When req_fp = 1, the access is treated as 4 bytes whatever req_size says, and alignment is checked against 4. A load result carries the 32 loaded bits in bits 31:0 and zero in bits 63:32, whatever req_signed says.
- R8: After an aligned load is accepted, req_ready is 0 until mem_rvalid is seen. rsp_valid is high for exactly the one cycle after the cycle in which mem_rvalid is seen, and req_ready is 1 again in that same cycle. Stores and trapped requests leave req_ready at 1.
- R9: After reset, req_ready is 1 and mem_valid, mem_be, trap_pulse and rsp_valid are 0.
- R10: An 8-byte load at an address that is a multiple of 8 returns mem_rdata unchanged, for either req_signed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 64 | Byte address |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_signed | input | 1 | Sign-extend a load result |
| req_fp | input | 1 | Single-precision floating-point mode |
| req_we | input | 1 | 1 store, 0 load |
| req_wdata | input | 64 | Store value, right-justified |
| mem_valid | output | 1 | Memory beat issued |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 64 | 8-byte-aligned address |
| mem_be | output | 8 | Byte lane enables |
| mem_wdata | output | 64 | Lane-placed store data |
| mem_rvalid | input | 1 | Load data returned |
| mem_rdata | input | 64 | Returned memory word |
| rsp_valid | output | 1 | Load result valid |
| rsp_data | output | 64 | Extended load result |
| trap_pulse | output | 1 | Misalignment trap |
| trap_addr | output | 64 | Faulting address |

## Verification
The memory beat outputs and the trap outputs are registered. They are due one clock after the edge that accepts a request. The load result is registered once more, so it is due one clock after the edge that samples mem_rvalid. The bench drives and samples only on falling edges. It checks the issue or trap outputs at the first falling edge after the accepting edge, and raises mem_rvalid at that same point. It then checks rsp_valid and rsp_data one falling edge later, and checks that rsp_valid has dropped on the falling edge after that.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int DATA_W = 64;
  localparam int ADDR_W = 64;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check #(
  parameter int LANES = 8,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  output logic             misaligned,
  output logic [LANES-1:0] lane_en
);
  logic [31:0] off_i;
  logic [31:0] n_i;
  logic [31:0] mask_i;

  assign off_i  = 32'(off);
  assign n_i    = 32'd1 << size;
  assign mask_i = n_i - 32'd1;
  assign misaligned = (off_i & mask_i) != 32'd0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_en[k] = (32'(k) >= off_i) && (32'(k) < off_i + n_i);
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int LANES = 8,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]   off,
  input  logic [1:0]         size,
  input  logic [LANES*8-1:0] wdata,
  output logic [LANES*8-1:0] lane_data
);
  logic [31:0]        n_i;
  logic [LANES*8-1:0] trimmed;

  assign n_i = 32'd1 << size;

  for (genvar k = 0; k < LANES; k++) begin : g_keep
    assign trimmed[8*k +: 8] = (32'(k) < n_i) ? wdata[8*k +: 8] : 8'h00;
  end

  assign lane_data = trimmed << (32'(off) * 32'd8);
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int LANES = 8,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]   off,
  input  logic [1:0]         size,
  input  logic               sign_en,
  input  logic [LANES*8-1:0] rdata,
  output logic [LANES*8-1:0] result
);
  logic [31:0]        n_i;
  logic [LANES*8-1:0] shifted;
  logic               top_bit;
  logic [7:0]         fill;

  assign n_i     = 32'd1 << size;
  assign shifted = rdata >> (32'(off) * 32'd8);

  always_comb begin
    top_bit = 1'b0;
    for (int s = 0; s <= OFF_W; s++) begin
      if (32'(size) == 32'(s)) top_bit = shifted[8 * (1 << s) - 1];
    end
  end

  assign fill = (sign_en && top_bit) ? 8'hFF : 8'h00;

  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign result[8*k +: 8] = (32'(k) < n_i) ? shifted[8*k +: 8] : fill;
  end
endmodule

// File: rtl/lsu_align_ext.sv
module lsu_align_ext
  import lsu_align_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_signed,
  input  logic          req_fp,
  input  logic          req_we,
  input  logic [DW-1:0] req_wdata,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [NL-1:0] mem_be,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          trap_pulse,
  output logic [AW-1:0] trap_addr
);
  acc_size_e     eff_size;
  logic [OW-1:0] req_off;
  logic          misaligned;
  logic [NL-1:0] lane_en;
  logic [DW-1:0] lane_data;
  logic          accept;
  logic          issue;

  logic          pend_q;
  logic [OW-1:0] ld_off_q;
  acc_size_e     ld_size_q;
  logic          ld_sign_q;
  logic [DW-1:0] ld_result;

  assign eff_size = req_fp ? SZ_WORD : acc_size_e'(req_size);
  assign req_off  = req_addr[OW-1:0];
  assign req_ready = ~pend_q;
  assign accept   = req_valid & req_ready;
  assign issue    = accept & ~misaligned;

  lsu_align_check #(.LANES(NL), .OFF_W(OW)) u_check (
    .off        (req_off),
    .size       (eff_size),
    .misaligned (misaligned),
    .lane_en    (lane_en)
  );

  lsu_store_lane #(.LANES(NL), .OFF_W(OW)) u_store (
    .off       (req_off),
    .size      (eff_size),
    .wdata     (req_wdata),
    .lane_data (lane_data)
  );

  lsu_load_extract #(.LANES(NL), .OFF_W(OW)) u_load (
    .off     (ld_off_q),
    .size    (ld_size_q),
    .sign_en (ld_sign_q),
    .rdata   (mem_rdata),
    .result  (ld_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_valid  <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      trap_pulse <= 1'b0;
      trap_addr  <= '0;
    end else begin
      mem_valid  <= issue;
      mem_we     <= issue & req_we;
      mem_be     <= issue ? lane_en : '0;
      mem_wdata  <= (issue & req_we) ? lane_data : '0;
      trap_pulse <= accept & misaligned;
      if (issue) mem_addr <= {req_addr[AW-1:OW], {OW{1'b0}}};
      if (accept & misaligned) trap_addr <= req_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      ld_off_q  <= '0;
      ld_size_q <= SZ_BYTE;
      ld_sign_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (issue & ~req_we) begin
        pend_q    <= 1'b1;
        ld_off_q  <= req_off;
        ld_size_q <= eff_size;
        ld_sign_q <= req_signed & ~req_fp;
      end else if (pend_q & mem_rvalid) begin
        pend_q <= 1'b0;
      end
      rsp_valid <= pend_q & mem_rvalid;
      if (pend_q & mem_rvalid) rsp_data <= ld_result;
    end
  end
endmodule

// File: rtl/lsu_align_ext_chk.sv
module lsu_align_ext_chk #(
  parameter int NL = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_valid,
  input logic [63:0]   mem_addr,
  input logic [NL-1:0] mem_be,
  input logic          mem_rvalid,
  input logic          rsp_valid,
  input logic          trap_pulse,
  input logic          pend_q
);
  AST_TRAP_NO_ISSUE: assert property (@(posedge clk) disable iff (rst)
    trap_pulse |-> (!mem_valid && mem_be == '0)); // R1
  AST_ISSUE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[2:0] == 3'd0)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_valid ^ trap_pulse)); // R2
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                   $countones(mem_be) == 4 || $countones(mem_be) == 8)); // R3
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !req_ready); // R8
  AST_RSP_DUE: assert property (@(posedge clk) disable iff (rst)
    (pend_q && mem_rvalid) |=> (rsp_valid && req_ready)); // R8
  AST_RSP_ONLY_AFTER: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(pend_q && mem_rvalid)); // R8
endmodule

bind lsu_align_ext lsu_align_ext_chk #(.NL(NL)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_valid  (mem_valid),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_rvalid (mem_rvalid),
  .rsp_valid  (rsp_valid),
  .trap_pulse (trap_pulse),
  .pend_q     (pend_q)
);

// File: tb/lsu_align_ext_bench.sv
module lsu_align_ext_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_signed = 1'b0;
  logic        req_fp = 1'b0;
  logic        req_we = 1'b0;
  logic [63:0] req_wdata = '0;
  logic        mem_valid;
  logic        mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        trap_pulse;
  logic [63:0] trap_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  lsu_align_ext u_lsu_align_ext (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz, input logic fp);
    return fp ? 4 : (1 << sz);
  endfunction

  function automatic logic [7:0] exp_be(input logic [2:0] off, input int n);
    logic [15:0] m;
    m = ((16'd1 << n) - 16'd1) << off;
    return m[7:0];
  endfunction

  function automatic logic [63:0] exp_wdata(input logic [63:0] wd, input logic [2:0] off, input int n);
    logic [63:0] k;
    k = (n == 8) ? wd : (wd & ((64'd1 << (8 * n)) - 64'd1));
    return k << (8 * off);
  endfunction

  function automatic logic [63:0] exp_load(input logic [63:0] rd, input logic [2:0] off,
                                           input int n, input logic sg);
    logic [63:0] sh;
    logic [63:0] v;
    sh = rd >> (8 * off);
    if (n == 8) return sh;
    v = sh & ((64'd1 << (8 * n)) - 64'd1);
    if (sg && sh[8 * n - 1]) v = v | ~((64'd1 << (8 * n)) - 64'd1);
    return v;
  endfunction

  task automatic do_access(input logic [63:0] a, input logic [1:0] sz, input logic sg,
                           input logic fp, input logic we, input logic [63:0] wd,
                           input logic [63:0] rd);
    int n;
    logic [2:0] off;
    logic mis;
    n   = nbytes(sz, fp);
    off = a[2:0];
    mis = (32'(off) & (n - 1)) != 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_signed = sg;
    req_fp = fp; req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (mis) begin
      check(fp ? "R7 trap" : "R1 trap", 64'(trap_pulse), 64'd1);
      check("R1 trap_addr", trap_addr, a);
      check("R1 no issue", {55'd0, mem_valid, mem_be}, 64'd0);
      check("R8 ready after trap", 64'(req_ready), 64'd1);
    end else begin
      check("R2 mem_valid", {62'd0, mem_valid, trap_pulse}, 64'd2);
      check("R2 mem_addr", mem_addr, {a[63:3], 3'b000});
      check("R2 mem_we", 64'(mem_we), 64'(we));
      check(fp ? "R7 be" : "R3 be", 64'(mem_be), 64'(exp_be(off, n)));
      if (we) begin
        check("R4 wdata", mem_wdata, exp_wdata(wd, off, n));
        check("R8 ready after store", 64'(req_ready), 64'd1);
      end else begin
        check("R8 stall", 64'(req_ready), 64'd0);
        mem_rvalid = 1'b1; mem_rdata = rd;
        @(negedge clk);
        mem_rvalid = 1'b0;
        check("R8 rsp_valid", {62'd0, rsp_valid, req_ready}, 64'd3);
        if (fp)          check("R7 fp load", rsp_data, exp_load(rd, off, 4, 1'b0));
        else if (n == 8) check("R10 dword load", rsp_data, rd);
        else if (sg)     check("R6 signed load", rsp_data, exp_load(rd, off, n, 1'b1));
        else             check("R5 unsigned load", rsp_data, exp_load(rd, off, n, 1'b0));
        @(negedge clk);
        check("R8 rsp pulse", 64'(rsp_valid), 64'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] ra, rw, rr;
    process::self().srandom(32'd12345);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset ready", 64'(req_ready), 64'd1);
    check("R9 reset outputs", {52'd0, mem_valid, trap_pulse, rsp_valid, 1'b0, mem_be}, 64'd0);
    // directed corners
    do_access(64'h1000, 2'd3, 1'b1, 1'b0, 1'b0, 0, 64'h8877665544332211); // R10
    do_access(64'h1003, 2'd0, 1'b1, 1'b0, 1'b0, 0, 64'h0000_0000_8000_0000); // R6 byte 0x80
    do_access(64'h1006, 2'd1, 1'b0, 1'b0, 1'b0, 0, 64'hFFEE_0000_0000_0000); // R5
    do_access(64'h1004, 2'd2, 1'b1, 1'b1, 1'b0, 0, 64'hC000_0000_0000_0000); // R7
    do_access(64'h1002, 2'd3, 1'b1, 1'b1, 1'b0, 0, 0); // R7 trap on 4-byte check
    do_access(64'h1004, 2'd0, 1'b0, 1'b1, 1'b0, 0, 64'h1234_5678_0000_0000); // R7 size ignored
    do_access(64'hFFFF_FFFF_FFFF_FFFC, 2'd3, 1'b0, 1'b0, 1'b0, 0, 0); // R1
    do_access(64'h2005, 2'd1, 1'b0, 1'b0, 1'b1, 64'hAAAA, 0); // R1
    do_access(64'h2007, 2'd0, 1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FF5A, 0); // R4
    do_access(64'h2004, 2'd2, 1'b0, 1'b0, 1'b1, 64'h1111_2222_3333_4444, 0); // R4
    for (int i = 0; i < 400; i++) begin
      ra = {$urandom, $urandom};
      rw = {$urandom, $urandom};
      rr = {$urandom, $urandom};
      if (($urandom % 3) == 0) ra[2:0] = 3'd0;
      do_access(ra, 2'($urandom), 1'($urandom), (($urandom % 5) == 0), 1'($urandom), rw, rr);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule